// File: doc/BRIEF.md
# Tapped-Delay-Line Timestamp Encoder

This block turns the registered snapshot of a tapped delay line into edge timestamps. It takes the snapshot and the value of a free-running coarse cycle counter on every system clock. It watches the youngest tap for a change of level; each change is one input transition. For each transition it reports the polarity and a timestamp. The timestamp is the coarse count scaled to fine units, minus the fine time the front has already covered inside the line.

The fine time is not the raw tap count. The tap reach (how far the new level has spread) selects an entry in a writable calibration table, so taps with unequal delays are handled. Calibration software loads the table through a write port. That port accepts writes only while the calibration input is held high, and the block reports no edges while that input is high.

Results leave as a single-cycle `valid_o` pulse with `rise_o` and `ts_o`. The source is a physical signal that cannot wait, so this output has no ready input and applies no back-pressure: the consumer must take a result in every cycle in which `valid_o` is high. The input side has no handshake either, and a snapshot is taken on every clock.

Top module: `tdc_stamp_encoder`

## Requirements
- R1: While `rst_ni` is low, and immediately after it, `valid_o`, `rise_o` and `ts_o` are all 0.
- R2: A snapshot whose tap 0 differs from tap 0 of the previous snapshot produces exactly one result. A snapshot with an unchanged tap 0 produces none. The first snapshot after reset never produces a result.
- R3: `rise_o` is 1 when the new tap 0 level is 1 (a rising transition) and 0 when it is 0 (a falling transition).
- R4: The reach is one less than the lowest tap index above 0 whose bit differs from tap 0. It is TAPS-1 when no tap differs. A stray differing bit above that lowest index does not change the reach.
- R5: The fine value is the calibration entry addressed by the reach. After reset, entry k holds floor((k+1)·CLK_UNITS/TAPS).
- R6: `ts_o` = (coarse·CLK_UNITS − fine) modulo 2^TS_W, where TS_W = COARSE_W + clog2(CLK_UNITS+1). The coarse value is the `coarse_i` value sampled together with the snapshot.
- R7: A snapshot sampled on clock edge n gives its result on the outputs after edge n+2. This latency is the same for every result.
- R8: When `cal_i` and `lut_we_i` are both high on an edge, entry `lut_addr_i` takes `lut_data_i`. When `cal_i` is low, a write strobe has no effect on the table.
- R9: A snapshot sampled while `cal_i` is high produces no result. Tap 0 is still tracked during that time, so leaving calibration with an unchanged level does not report an edge.
- R10: The snapshot has TAPS = 4·STAGES bits, and tap 0 is the youngest tap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| taps_i | input | TAPS | Registered delay-line snapshot, tap 0 youngest |
| coarse_i | input | COARSE_W | Free-running coarse cycle count |
| cal_i | input | 1 | Calibration mode: enables table writes, mutes results |
| lut_we_i | input | 1 | Calibration table write strobe |
| lut_addr_i | input | clog2(TAPS) | Calibration table write address (reach value) |
| lut_data_i | input | FINE_W | Calibration table write data (fine units) |
| valid_o | output | 1 | One-cycle result pulse |
| rise_o | output | 1 | Polarity of the reported transition, 1 = rising |
| ts_o | output | TS_W | Timestamp in fine units |

## Verification
The bench builds the block with STAGES=4 (16 taps), COARSE_W=6, FINE_W=8 and CLK_UNITS=160. This makes 16 reach values, so every reach can be swept for both polarities, once against the reset table and once against a fully reprogrammed table. With a 14-bit timestamp, a coarse count of 0 forces the subtraction to wrap, and a coarse count of 63 covers the top of the range. Bubble patterns, edges on consecutive cycles, writes attempted outside calibration, and edges hidden by calibration are also run in this small configuration.

// File: rtl/tdc_pkg.sv
`timescale 1ns/1ps
package tdc_pkg;

  typedef enum logic {
    POL_FALL = 1'b0,
    POL_RISE = 1'b1
  } tdc_pol_e;

  // Reset contents of the calibration table: uniform tap spacing.
  function automatic int default_fine(int k, int clk_units, int taps);
    return ((k + 1) * clk_units) / taps;
  endfunction

endpackage

// File: rtl/tdc_front_find.sv
`timescale 1ns/1ps
module tdc_front_find #(
  parameter int TAPS  = 16,
  parameter int IDX_W = 4
) (
  input  logic [TAPS-1:0]  taps_i,
  output logic [IDX_W-1:0] reach_o
);

  logic [TAPS-1:0] differs;

  assign differs[0] = 1'b0;
  for (genvar g = 1; g < TAPS; g++) begin : g_diff
    assign differs[g] = taps_i[g] ^ taps_i[0];
  end

  // Lowest differing tap wins; bubbles further up are ignored.
  always_comb begin
    reach_o = IDX_W'(TAPS - 1);
    for (int i = TAPS - 1; i >= 1; i--) begin
      if (differs[i]) reach_o = IDX_W'(i - 1);
    end
  end

endmodule

// File: rtl/tdc_fine_lut.sv
`timescale 1ns/1ps
module tdc_fine_lut
  import tdc_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int FINE_W    = 8,
  parameter int CLK_UNITS = 160,
  localparam int AW       = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [FINE_W-1:0] wr_data_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [FINE_W-1:0] rd_data_o
);

  logic [FINE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < DEPTH; k++) begin
        mem[k] <= FINE_W'(default_fine(k, CLK_UNITS, DEPTH));
      end
      rd_data_o <= '0;
    end else begin
      if (wr_en_i && (int'(wr_addr_i) < DEPTH)) mem[wr_addr_i] <= wr_data_i;
      rd_data_o <= mem[rd_addr_i];
    end
  end

endmodule

// File: rtl/tdc_stamp_encoder.sv
`timescale 1ns/1ps
module tdc_stamp_encoder
  import tdc_pkg::*;
#(
  parameter int STAGES    = 4,
  parameter int COARSE_W  = 6,
  parameter int FINE_W    = 8,
  parameter int CLK_UNITS = 160,
  localparam int TAPS     = 4 * STAGES,
  localparam int IDX_W    = $clog2(TAPS),
  localparam int CU_W     = $clog2(CLK_UNITS + 1),
  localparam int TS_W     = COARSE_W + CU_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [TAPS-1:0]     taps_i,
  input  logic [COARSE_W-1:0] coarse_i,
  input  logic                cal_i,
  input  logic                lut_we_i,
  input  logic [IDX_W-1:0]    lut_addr_i,
  input  logic [FINE_W-1:0]   lut_data_i,
  output logic                valid_o,
  output logic                rise_o,
  output logic [TS_W-1:0]     ts_o
);

  localparam logic [TS_W-1:0] PERIOD = TS_W'(CLK_UNITS);

  // Stage 1: edge detection and front position
  logic                tap0_q;
  logic                primed_q;
  logic [IDX_W-1:0]    reach_c;
  logic                s1_vld;
  tdc_pol_e            s1_pol;
  logic [IDX_W-1:0]    s1_reach;
  logic [COARSE_W-1:0] s1_coarse;

  tdc_front_find #(.TAPS(TAPS), .IDX_W(IDX_W)) u_find (
    .taps_i  (taps_i),
    .reach_o (reach_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tap0_q    <= 1'b0;
      primed_q  <= 1'b0;
      s1_vld    <= 1'b0;
      s1_pol    <= POL_FALL;
      s1_reach  <= '0;
      s1_coarse <= '0;
    end else begin
      tap0_q    <= taps_i[0];
      primed_q  <= 1'b1;
      s1_vld    <= primed_q && !cal_i && (taps_i[0] != tap0_q);
      s1_pol    <= tdc_pol_e'(taps_i[0]);
      s1_reach  <= reach_c;
      s1_coarse <= coarse_i;
    end
  end

  // Stage 2: calibration lookup (registered read)
  logic [FINE_W-1:0]   s2_fine;
  logic                s2_vld;
  tdc_pol_e            s2_pol;
  logic [COARSE_W-1:0] s2_coarse;

  tdc_fine_lut #(.DEPTH(TAPS), .FINE_W(FINE_W), .CLK_UNITS(CLK_UNITS)) u_lut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (cal_i && lut_we_i),
    .wr_addr_i (lut_addr_i),
    .wr_data_i (lut_data_i),
    .rd_addr_i (s1_reach),
    .rd_data_o (s2_fine)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_vld    <= 1'b0;
      s2_pol    <= POL_FALL;
      s2_coarse <= '0;
    end else begin
      s2_vld    <= s1_vld;
      s2_pol    <= s1_pol;
      s2_coarse <= s1_coarse;
    end
  end

  // Stage 3: combine coarse and fine
  logic [TS_W-1:0] stamp_c;
  assign stamp_c = (TS_W'(s2_coarse) * PERIOD) - TS_W'(s2_fine);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      rise_o  <= 1'b0;
      ts_o    <= '0;
    end else begin
      valid_o <= s2_vld;
      if (s2_vld) begin
        rise_o <= (s2_pol == POL_RISE);
        ts_o   <= stamp_c;
      end
    end
  end

endmodule

// File: rtl/tdc_stamp_chk.sv
`timescale 1ns/1ps
module tdc_stamp_chk (
  input logic clk,
  input logic rst_n,
  input logic tap0,
  input logic cal,
  input logic valid,
  input logic pol
);

  logic [2:0] age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 3'd7) age <= age + 3'd1;
  end

  // R2 and R7: no result can be complete before four edges have passed since reset
  p_quiet_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (age < 3'd4) |-> !valid);

  // R2: every result traces back to a change of tap 0
  p_needs_change_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd4 && valid) |-> ($past(tap0, 3) != $past(tap0, 4)));

  // R2 and R9: a change outside calibration is always reported
  p_change_seen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd4 && !$past(cal, 3) && ($past(tap0, 3) != $past(tap0, 4))) |-> valid);

  // R3: polarity equals the new level of tap 0
  p_polarity_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd4 && valid) |-> (pol == $past(tap0, 3)));

  // R9: snapshots taken in calibration mode never yield a result
  p_cal_mute_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd4 && valid) |-> !$past(cal, 3));

endmodule

bind tdc_stamp_encoder tdc_stamp_chk u_chk (
  .clk   (clk_i),
  .rst_n (rst_ni),
  .tap0  (taps_i[0]),
  .cal   (cal_i),
  .valid (valid_o),
  .pol   (rise_o)
);

// File: tb/tb_tdc_stamp_encoder.sv
`timescale 1ns/1ps
module tb_tdc_stamp_encoder;

  localparam int STAGES    = 4;
  localparam int COARSE_W  = 6;
  localparam int FINE_W    = 8;
  localparam int CLK_UNITS = 160;
  localparam int TAPS      = 4 * STAGES;              // R10
  localparam int IDX_W     = $clog2(TAPS);
  localparam int TS_W      = COARSE_W + $clog2(CLK_UNITS + 1);

  logic                clk = 1'b0;
  logic                rst_n;
  logic [TAPS-1:0]     taps_i;
  logic [COARSE_W-1:0] coarse_i;
  logic                cal_i;
  logic                lut_we_i;
  logic [IDX_W-1:0]    lut_addr_i;
  logic [FINE_W-1:0]   lut_data_i;
  logic                valid_o;
  logic                rise_o;
  logic [TS_W-1:0]     ts_o;

  always #10 clk = ~clk;   // 50 MHz

  tdc_stamp_encoder #(
    .STAGES(STAGES), .COARSE_W(COARSE_W), .FINE_W(FINE_W), .CLK_UNITS(CLK_UNITS)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .taps_i(taps_i), .coarse_i(coarse_i),
    .cal_i(cal_i), .lut_we_i(lut_we_i), .lut_addr_i(lut_addr_i),
    .lut_data_i(lut_data_i), .valid_o(valid_o), .rise_o(rise_o), .ts_o(ts_o)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // Bench model state
  int   m_lut [TAPS];
  logic m_prev;
  bit   e_v  [3];
  bit   e_p  [3];
  int   e_ts [3];

  function automatic logic [TAPS-1:0] front(logic lv, int r);
    logic [TAPS-1:0] v;
    for (int i = 0; i < TAPS; i++) v[i] = (i <= r) ? lv : ~lv;
    return v;
  endfunction

  // One clock of stimulus; checks the result of the snapshot driven three steps earlier (R7).
  task automatic step(input logic [TAPS-1:0] t, input int co, input logic cal,
                      input logic we, input int addr, input int data);
    int r;
    int x;
    @(negedge clk);
    n_chk++;
    if (valid_o !== e_v[2]) begin
      n_fail++;
      $display("FAIL R2 valid_o actual %0b expected %0b", valid_o, e_v[2]);
    end
    if (e_v[2]) begin
      n_chk++;
      if (rise_o !== e_p[2]) begin
        n_fail++;
        $display("FAIL R3 rise_o actual %0b expected %0b", rise_o, e_p[2]);
      end
      n_chk++;
      if (ts_o !== TS_W'(e_ts[2])) begin
        n_fail++;
        $display("FAIL R6 ts_o actual %0d expected %0d", ts_o, e_ts[2]);
      end
    end
    for (int s = 2; s > 0; s--) begin
      e_v[s] = e_v[s-1]; e_p[s] = e_p[s-1]; e_ts[s] = e_ts[s-1];
    end
    taps_i     = t;
    coarse_i   = COARSE_W'(co);
    cal_i      = cal;
    lut_we_i   = we;
    lut_addr_i = IDX_W'(addr);
    lut_data_i = FINE_W'(data);
    // R4: reach from the lowest tap that differs from tap 0
    r = TAPS - 1;
    for (int i = TAPS - 1; i >= 1; i--) if (t[i] != t[0]) r = i - 1;
    x = co * CLK_UNITS - m_lut[r];
    if (x < 0) x += (1 << TS_W);
    e_v[0]  = !cal && (t[0] != m_prev);
    e_p[0]  = t[0];
    e_ts[0] = x;
    m_prev  = t[0];
    if (cal && we) m_lut[addr] = data;   // R8
  endtask

  task automatic idle(input logic lv, input int n);
    for (int k = 0; k < n; k++) step({TAPS{lv}}, 0, 1'b0, 1'b0, 0, 0);
  endtask

  // Steady old level, one snapshot with the front at reach r, then steady new level.
  task automatic edge_at(input logic lv, input int r, input int co);
    step({TAPS{~lv}}, 5, 1'b0, 1'b0, 0, 0);
    step(front(lv, r), co, 1'b0, 1'b0, 0, 0);
    step({TAPS{lv}}, 9, 1'b0, 1'b0, 0, 0);
  endtask

  task automatic sweep(input int salt);
    for (int pl = 0; pl < 2; pl++) begin
      for (int r = 0; r < TAPS; r++) begin
        edge_at(pl[0], r, (r * 11 + pl * 5 + salt) % (1 << COARSE_W));
      end
    end
  endtask

  initial begin
    #(64'd20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL R7 watchdog actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; taps_i = '1; coarse_i = '0; cal_i = 1'b0;
    lut_we_i = 1'b0; lut_addr_i = '0; lut_data_i = '0;
    for (int k = 0; k < TAPS; k++) m_lut[k] = ((k + 1) * CLK_UNITS) / TAPS;   // R5 reset table
    for (int s = 0; s < 3; s++) begin e_v[s] = 1'b0; e_p[s] = 1'b0; e_ts[s] = 0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    n_chk++;
    if (valid_o !== 1'b0 || rise_o !== 1'b0 || ts_o !== '0) begin
      n_fail++;
      $display("FAIL R1 reset outputs actual %0b/%0b/%0d expected 0/0/0", valid_o, rise_o, ts_o);
    end
    // R2: first snapshot after reset has tap 0 = 1 against a cleared history; no result
    rst_n  = 1'b1;
    m_prev = 1'b1;
    idle(1'b1, 4);

    // R4 R5 R6 R7: every reach, both polarities, reset table
    sweep(1);
    // R6: wrap below zero and top of coarse range
    edge_at(1'b1, TAPS - 1, 0);
    edge_at(1'b0, 0, (1 << COARSE_W) - 1);

    // R4: bubbles above the front are ignored
    idle(1'b0, 2);
    step(front(1'b1, 2) | (TAPS'(1) << 5), 17, 1'b0, 1'b0, 0, 0);
    idle(1'b1, 2);
    step(front(1'b0, 6) & ~(TAPS'(1) << 10), 33, 1'b0, 1'b0, 0, 0);
    idle(1'b0, 2);

    // R8: write strobe outside calibration leaves entry 4 at its reset value
    step({TAPS{1'b0}}, 0, 1'b0, 1'b1, 4, 99);
    edge_at(1'b1, 4, 10);

    // R9: edges inside calibration are muted; R8: reprogram the whole table
    step({TAPS{1'b1}}, 3, 1'b1, 1'b0, 0, 0);
    step({TAPS{1'b0}}, 4, 1'b1, 1'b0, 0, 0);
    for (int k = 0; k < TAPS; k++) step({TAPS{1'b0}}, 0, 1'b1, 1'b1, k, (k * 13 + 7) % 256);
    step({TAPS{1'b1}}, 6, 1'b1, 1'b0, 0, 0);
    idle(1'b1, 3);   // R9: leaving calibration with tap 0 unchanged reports nothing

    // R5 R6: sweep against the programmed table
    sweep(2);

    // R2: transitions on consecutive snapshots
    idle(1'b0, 2);
    step(front(1'b1, 3), 20, 1'b0, 1'b0, 0, 0);
    step(front(1'b0, 5), 21, 1'b0, 1'b0, 0, 0);
    step(front(1'b1, 8), 22, 1'b0, 1'b0, 0, 0);
    idle(1'b1, 5);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule